// File: doc/BRIEF.md
# I/O Port Write Snooper

This block observes the host's I/O write cycles, each presented as a 16-bit port address, a data byte and a single-cycle strobe. It compares every write against two programmable port addresses. A boot-progress code port is a typical target. On a match it keeps the byte as that channel's latest value and raises a sticky per-channel status flag. Each channel has its own capture enable and interrupt enable. The interrupt line is high for as long as an enabled flag stays set.

A small local register port sets up the block and reads it back. A write of one to a status bit clears that bit. Each channel also keeps a short history of captured bytes in a FIFO. When the FIFO is full, the oldest byte is dropped so that the newest capture is always kept. Software drains each history through a valid/ready pop stream. `hist_valid` doubles as the not-empty flag. Holding `hist_ready` low stalls the reader but never the host: captures still enter, and on overflow they push the oldest entries out. The second channel is optional and may stay disabled while the first one runs.

Top module: `ioport_snooper`

## Requirements
- R1: After reset every register reads zero, `irq` is low and both `hist_valid` bits are low.
- R2: A channel captures a write only when `io_wr_stb` is high, its capture enable is set and all 16 address bits equal its port address. The captured byte appears in the data register on the cycle after the strobe.
- R3: Register select 0 is control, with bit 0 the channel 0 capture enable, bit 1 the channel 0 interrupt enable, bit 2 the channel 1 capture enable and bit 3 the channel 1 interrupt enable. Select 2 holds the channel 0 port address in [15:0] and the channel 1 port address in [31:16]. Select 3 returns the channel 0 latest byte in [7:0] and the channel 1 latest byte in [15:8]. Unused bits read zero.
- R4: Select 1 is status, with bit 0 for channel 0 and bit 1 for channel 1. A capture sets its bit. Writing 1 to a bit clears it, and writing 0 leaves it unchanged.
- R5: When a capture and a clear hit the same status bit in the same cycle, the bit stays set.
- R6: `irq` is high exactly while some status bit is set whose interrupt enable is also set.
- R7: Each channel's history returns captured bytes in capture order. A byte is popped on a cycle where `hist_valid` and `hist_ready` are both high, and the byte is shown on `hist_data`, with channel c in bits [8c+7:8c].
- R8: A capture into a full history discards the oldest entry. The history then holds the newest DEPTH bytes.
- R9: The channels act independently. A disabled channel captures nothing, and if both channels are programmed with the same port and enabled, both capture the write.
- R10: A pop and a capture in the same cycle on a full history lose only the popped byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_wr_stb | input | 1 | Host I/O write strobe |
| io_wr_addr | input | 16 | Host I/O write port address |
| io_wr_data | input | 8 | Host I/O write data byte |
| cfg_we | input | 1 | Register write enable |
| cfg_sel | input | 2 | Register select |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (selected by cfg_sel) |
| irq | output | 1 | Interrupt request |
| hist_valid | output | 2 | History not empty, per channel |
| hist_ready | input | 2 | History pop request, per channel |
| hist_data | output | 16 | History head byte, per channel |

## Verification
The bench builds the block with a history depth of 4. With that depth, overflow and the discard-oldest rule are reached after only five captures. The same depth makes the simultaneous pop-and-capture case on a full queue a frequent event in the random phase. The port addresses include pairs that differ in a single high address bit, and at one point both channels share one port, so the full-width compare and the channel independence are both exercised.

// File: rtl/snoop_pkg.sv
package snoop_pkg;
  localparam int NUM_CH = 2;
  localparam int PORT_W = 16;
  localparam int BYTE_W = 8;
  localparam int REG_W  = 32;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_STAT = 2'd1,
    SEL_PORT = 2'd2,
    SEL_DATA = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/snoop_chan.sv
module snoop_chan #(
  parameter int PORT_W = 16,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic [PORT_W-1:0] port_addr,
  input  logic              wr_stb,
  input  logic [PORT_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              clr,
  output logic              hit,
  output logic [BYTE_W-1:0] latest,
  output logic              status
);
  assign hit = wr_stb && cap_en && (wr_addr == port_addr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      latest <= '0;
      status <= 1'b0;
    end else begin
      if (hit) latest <= wr_data;
      status <= hit | (status & ~clr);
    end
  end

  p_status_on_hit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> status);
  p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !hit) |=> !status);
  p_capture_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && clr) |=> status);
  p_disabled_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_en |=> $stable(latest));
endmodule

// File: rtl/snoop_hist_fifo.sv
module snoop_hist_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop_ready,
  output logic         out_valid,
  output logic [W-1:0] out_data
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] rd_ptr, wr_ptr;
  logic [CW-1:0] count;
  logic          full, do_pop;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full      = (count == CW'(DEPTH));
  assign out_valid = (count != '0);
  assign do_pop    = out_valid && pop_ready;
  assign out_data  = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= nxt(wr_ptr);
      if (do_pop || (push && full)) rd_ptr <= nxt(rd_ptr);
      if (push && !do_pop && !full) count <= count + 1'b1;
      else if (do_pop && !push)     count <= count - 1'b1;
    end
  end

  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  p_drop_keeps_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !do_pop) |=> full);
  p_pop_push_full_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && do_pop) |=> full);
  p_push_not_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> out_valid);
endmodule

// File: rtl/snoop_regs.sv
module snoop_regs
  import snoop_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_sel,
  input  logic [REG_W-1:0] cfg_wdata,
  output logic [2*NUM_CH-1:0]      ctrl,
  output logic [NUM_CH*PORT_W-1:0] ports,
  output logic [NUM_CH-1:0]        clr
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl  <= '0;
      ports <= '0;
    end else if (cfg_we) begin
      if (cfg_sel == SEL_CTRL) ctrl  <= cfg_wdata[2*NUM_CH-1:0];
      if (cfg_sel == SEL_PORT) ports <= cfg_wdata[NUM_CH*PORT_W-1:0];
    end
  end

  assign clr = (cfg_we && cfg_sel == SEL_STAT) ? cfg_wdata[NUM_CH-1:0] : '0;
endmodule

// File: rtl/ioport_snooper.sv
module ioport_snooper
  import snoop_pkg::*;
#(
  parameter int HIST_DEPTH = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        io_wr_stb,
  input  logic [15:0] io_wr_addr,
  input  logic [7:0]  io_wr_data,
  input  logic        cfg_we,
  input  logic [1:0]  cfg_sel,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  output logic        irq,
  output logic [1:0]  hist_valid,
  input  logic [1:0]  hist_ready,
  output logic [15:0] hist_data
);
  logic [2*NUM_CH-1:0]      ctrl;
  logic [NUM_CH*PORT_W-1:0] ports;
  logic [NUM_CH-1:0]        clr, hit, status, int_en;
  logic [NUM_CH*BYTE_W-1:0] latest;

  snoop_regs u_regs (
    .clk, .rst_n, .cfg_we, .cfg_sel, .cfg_wdata,
    .ctrl, .ports, .clr
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign int_en[c] = ctrl[2*c+1];

    snoop_chan #(.PORT_W(PORT_W), .BYTE_W(BYTE_W)) u_chan (
      .clk, .rst_n,
      .cap_en    (ctrl[2*c]),
      .port_addr (ports[c*PORT_W +: PORT_W]),
      .wr_stb    (io_wr_stb),
      .wr_addr   (io_wr_addr),
      .wr_data   (io_wr_data),
      .clr       (clr[c]),
      .hit       (hit[c]),
      .latest    (latest[c*BYTE_W +: BYTE_W]),
      .status    (status[c])
    );

    snoop_hist_fifo #(.DEPTH(HIST_DEPTH), .W(BYTE_W)) u_hist (
      .clk, .rst_n,
      .push      (hit[c]),
      .push_data (io_wr_data),
      .pop_ready (hist_ready[c]),
      .out_valid (hist_valid[c]),
      .out_data  (hist_data[c*BYTE_W +: BYTE_W])
    );
  end

  assign irq = |(status & int_en);

  always_comb begin
    cfg_rdata = '0;
    case (reg_sel_e'(cfg_sel))
      SEL_CTRL: cfg_rdata[2*NUM_CH-1:0]      = ctrl;
      SEL_STAT: cfg_rdata[NUM_CH-1:0]        = status;
      SEL_PORT: cfg_rdata[NUM_CH*PORT_W-1:0] = ports;
      SEL_DATA: cfg_rdata[NUM_CH*BYTE_W-1:0] = latest;
      default:  cfg_rdata = '0;
    endcase
  end

  p_irq_ch0_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (hit[0] && int_en[0] && !(cfg_we && cfg_sel == SEL_CTRL)) |=> irq);
  p_irq_ch1_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (hit[1] && int_en[1] && !(cfg_we && cfg_sel == SEL_CTRL)) |=> irq);
  p_irq_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (status == '0) |-> !irq);
  p_reset_quiet_r1: assert property (@(posedge clk)
    $past(!rst_n) |-> (status == '0 && hist_valid == '0));
endmodule

// File: tb/ioport_snooper_tb.sv
`timescale 1ns/1ps
module ioport_snooper_tb;
  localparam int DEPTH = 4;

  logic clk = 0, rst_n = 0;
  logic io_wr_stb = 0;
  logic [15:0] io_wr_addr = 0;
  logic [7:0]  io_wr_data = 0;
  logic cfg_we = 0;
  logic [1:0]  cfg_sel = 0;
  logic [31:0] cfg_wdata = 0;
  logic [31:0] cfg_rdata;
  logic irq;
  logic [1:0]  hist_valid;
  logic [1:0]  hist_ready = 0;
  logic [15:0] hist_data;

  always #10 clk = ~clk;

  ioport_snooper #(.HIST_DEPTH(DEPTH)) u_dut (.*);

  int n_cmp = 0, n_bad = 0;
  logic [3:0]  m_ctrl = 0;
  logic [31:0] m_port = 0;
  logic [1:0]  m_stat = 0;
  logic [7:0]  m_lat0 = 0, m_lat1 = 0;
  logic [7:0]  mq0[$], mq1[$];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FIFO-less FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #2;
  endtask

  task automatic rd(input logic [1:0] sel, output logic [31:0] v);
    cfg_sel = sel; #1; v = cfg_rdata;
  endtask

  function automatic logic exp_irq();
    return (m_stat[0] && m_ctrl[1]) || (m_stat[1] && m_ctrl[3]);
  endfunction

  task automatic cfg_write(input string tag, input logic [1:0] sel, input logic [31:0] v);
    logic [31:0] rv;
    cfg_we = 1; cfg_sel = sel; cfg_wdata = v;
    tick();
    cfg_we = 0;
    case (sel)
      2'd0: m_ctrl = v[3:0];
      2'd1: m_stat = m_stat & ~v[1:0];
      2'd2: m_port = v;
      default: ;
    endcase
    rd(2'd0, rv); chk({tag, " R3 ctrl"}, rv, {28'd0, m_ctrl});
    rd(2'd2, rv); chk({tag, " R3 port"}, rv, m_port);
    rd(2'd1, rv); chk({tag, " R4 status"}, rv, {30'd0, m_stat});
    chk({tag, " R6 irq"}, irq, exp_irq());
  endtask

  task automatic do_cycle(input string tag, input logic stb, input logic [15:0] a,
                          input logic [7:0] d, input logic [1:0] clr, input logic [1:0] pop);
    logic [1:0] hit;
    logic [31:0] rv;
    io_wr_stb = stb; io_wr_addr = a; io_wr_data = d;
    cfg_we = (clr != 0); cfg_sel = 2'd1; cfg_wdata = {30'd0, clr};
    hist_ready = pop;
    #1;
    if (pop[0]) begin
      chk({tag, " R7 valid0"}, hist_valid[0], mq0.size() > 0);
      if (mq0.size() > 0) chk({tag, " R7 data0"}, hist_data[7:0], mq0[0]);
    end
    if (pop[1]) begin
      chk({tag, " R7 valid1"}, hist_valid[1], mq1.size() > 0);
      if (mq1.size() > 0) chk({tag, " R7 data1"}, hist_data[15:8], mq1[0]);
    end
    hit[0] = stb && m_ctrl[0] && (a == m_port[15:0]);
    hit[1] = stb && m_ctrl[2] && (a == m_port[31:16]);
    tick();
    io_wr_stb = 0; cfg_we = 0; hist_ready = 0;
    if (pop[0] && mq0.size() > 0) void'(mq0.pop_front());
    if (pop[1] && mq1.size() > 0) void'(mq1.pop_front());
    if (hit[0]) begin
      if (mq0.size() == DEPTH) void'(mq0.pop_front());
      mq0.push_back(d); m_lat0 = d;
    end
    if (hit[1]) begin
      if (mq1.size() == DEPTH) void'(mq1.pop_front());
      mq1.push_back(d); m_lat1 = d;
    end
    m_stat = hit | (m_stat & ~clr);
    rd(2'd3, rv); chk({tag, " R2 data"}, rv, {16'd0, m_lat1, m_lat0});
    rd(2'd1, rv); chk({tag, " R4 status"}, rv, {30'd0, m_stat});
    chk({tag, " R6 irq"}, irq, exp_irq());
  endtask

  task automatic drain(input string tag);
    while (mq0.size() > 0) do_cycle({tag, " R8 drain0"}, 0, 0, 0, 2'b00, 2'b01);
    while (mq1.size() > 0) do_cycle({tag, " R8 drain1"}, 0, 0, 0, 2'b00, 2'b10);
    #1;
    chk({tag, " R7 empty"}, hist_valid, 2'b00);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [31:0] rv;
    void'($urandom(32'h5EED));
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    tick();
    // R1: reset state
    for (int s = 0; s < 4; s++) begin
      rd(s[1:0], rv); chk("R1 reg", rv, 32'd0);
    end
    chk("R1 irq", irq, 0);
    chk("R1 hist", hist_valid, 2'b00);

    cfg_write("R3", 2'd2, 32'h0084_0080);
    cfg_write("R3", 2'd0, 32'h0000_0003);
    do_cycle("R2 match", 1, 16'h0080, 8'hA5, 0, 0);
    do_cycle("R9 ch1 off", 1, 16'h0084, 8'h11, 0, 0);
    do_cycle("R2 hi mismatch", 1, 16'h8080, 8'h22, 0, 0);
    do_cycle("R2 strobe low", 0, 16'h0080, 8'h33, 0, 0);
    cfg_write("R4 w0", 2'd1, 32'h0);
    cfg_write("R4 w1c", 2'd1, 32'h1);
    do_cycle("R2 again", 1, 16'h0080, 8'h44, 0, 0);
    do_cycle("R5 same cycle", 1, 16'h0080, 8'h55, 2'b01, 0);
    do_cycle("R4 clear", 0, 0, 0, 2'b01, 0);
    cfg_write("R6 ch1 no ie", 2'd0, 32'h0000_0007);
    do_cycle("R6 ch1", 1, 16'h0084, 8'h66, 0, 0);
    cfg_write("R9 shared", 2'd2, 32'h0080_0080);
    do_cycle("R9 both", 1, 16'h0080, 8'h77, 0, 0);
    drain("R7");
    for (int i = 0; i < DEPTH + 2; i++)
      do_cycle("R8 overflow", 1, 16'h0080, 8'h90 + i[7:0], 0, 0);
    do_cycle("R10 pop+push full", 1, 16'h0080, 8'hC0, 0, 2'b11);
    drain("R8");

    cfg_write("rand R3", 2'd2, 32'h1080_0080);
    cfg_write("rand R3", 2'd0, 32'h0000_000F);
    for (int i = 0; i < 400; i++) begin
      logic [15:0] a;
      int r;
      if (i == 200) cfg_write("rand R3", 2'd0, {28'd0, 4'($urandom)});
      r = $urandom % 4;
      case (r)
        0: a = m_port[15:0];
        1: a = m_port[31:16];
        2: a = 16'($urandom);
        default: a = m_port[15:0] ^ (16'd1 << ($urandom % 16));
      endcase
      do_cycle("rand R2", ($urandom % 4) != 0, a, 8'($urandom),
               (($urandom % 5) == 0) ? 2'($urandom) : 2'b00,
               {($urandom % 4) == 0, ($urandom % 4) == 0});
    end
    drain("rand R7");
    summary();
  end
endmodule